// File: doc/BRIEF.md
# Region Access Guard

This block sits beside a processor's instruction and data ports. It decides, within the same cycle, whether each access may proceed. It holds a table of eight regions in flip-flops. Each region has a base address, a power-of-two size, an enable bit and a set of permissions, kept apart for privileged and unprivileged code. Instruction fetches and data loads and stores are checked against this one table.

For every access the block takes an address, an access kind and a privilege flag. With no clock between input and output, it returns allow or fault, a hit flag and the index of the deciding region. The address passes through unchanged, because the block only protects memory and never relocates it. Software sets up the table through four word registers. It first picks a region with a select register, then reads or writes that region's base and attribute words.

Top module: `region_guard`

## Requirements
- R1: After reset every configuration register reads zero and the global enable is clear, so every access is allowed.
- R2: While the global enable (control register bit 0) is clear, every access is allowed whatever the region table holds.
- R3: An enabled region with size field N (attribute bits [5:1]) covers 2^(N+1) bytes starting at its base. The low N+1 base bits are ignored. A value of N below 4 acts as 4, giving 32 bytes, and N = 31 covers the whole 4 GB space.
- R4: When several enabled regions contain the address, the highest index decides. acc_hit_o is 1 and acc_region_o gives that index. With no match, acc_hit_o is 0 and acc_region_o is 0.
- R5: Access kind codes are 0 fetch, 1 read, 2 write; code 3 is checked as a read. A read needs the read bit and a write needs the write bit of the current level. The bits are attribute 8 (privileged read), 9 (privileged write), 10 (unprivileged read) and 11 (unprivileged write).
- R6: A fetch needs the current level's read bit and a clear execute-never bit. The execute-never bits are attribute bit 12 for privileged code and bit 13 for unprivileged code.
- R7: With the global enable set and no region matching, a privileged access is allowed and an unprivileged access faults.
- R8: The register offsets are 0 control, 1 region select, 2 base of the selected region and 3 attribute of the selected region. Base and attribute read back the full word last written. Control reads back only bit 0 and select reads back only bits [2:0]; all other bits of these two read zero.
- R9: Results appear in the same cycle as the access inputs. acc_fault_o is always the inverse of acc_allow_o, and acc_addr_o always equals acc_addr_i.
- R10: A region whose attribute bit 0 is clear takes no part in matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_req_i | input | 1 | Register access strobe |
| cfg_we_i | input | 1 | Write when set together with cfg_req_i |
| cfg_addr_i | input | 2 | Register word offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for cfg_addr_i |
| acc_addr_i | input | 32 | Access address |
| acc_type_i | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| acc_priv_i | input | 1 | 1 for privileged access |
| acc_addr_o | output | 32 | Address forwarded to memory, unchanged |
| acc_allow_o | output | 1 | Access permitted |
| acc_fault_o | output | 1 | Access refused |
| acc_hit_o | output | 1 | Some enabled region contains the address |
| acc_region_o | output | 3 | Index of the deciding region |

## Verification
The bench builds the guard with its default eight regions and a 32-bit address. This makes the whole-space region (N = 31) and the smallest, clamped size reachable with real addresses. Overlaps of a small region inside a medium one inside the full-space one exercise the highest-index rule at both edges of each window. A deliberately misaligned base and a size field below the minimum also reach the masking and clamping paths.

// File: rtl/rg_pkg.sv
`timescale 1ns/1ps
package rg_pkg;
  localparam int unsigned MIN_SIZE_LOG = 4;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_SEL  = 2'd1;
  localparam logic [1:0] REG_BASE = 2'd2;
  localparam logic [1:0] REG_ATTR = 2'd3;

  localparam int unsigned A_EN      = 0;
  localparam int unsigned A_SIZE_LO = 1;
  localparam int unsigned A_SIZE_HI = 5;
  localparam int unsigned A_PRD     = 8;
  localparam int unsigned A_PWR     = 9;
  localparam int unsigned A_URD     = 10;
  localparam int unsigned A_UWR     = 11;
  localparam int unsigned A_PXN     = 12;
  localparam int unsigned A_UXN     = 13;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_type_e;

  typedef struct packed {
    logic p_rd;
    logic p_wr;
    logic p_xn;
    logic u_rd;
    logic u_wr;
    logic u_xn;
  } perm_t;
endpackage

// File: rtl/rg_cfg_regs.sv
`timescale 1ns/1ps
module rg_cfg_regs
  import rg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               cfg_req_i,
  input  logic                               cfg_we_i,
  input  logic [1:0]                         cfg_addr_i,
  input  logic [DATA_W-1:0]                  cfg_wdata_i,
  output logic [DATA_W-1:0]                  cfg_rdata_o,
  output logic                               glob_en_o,
  output logic [NUM_REGIONS-1:0][DATA_W-1:0] base_o,
  output logic [NUM_REGIONS-1:0][DATA_W-1:0] attr_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS);

  logic                               en_q;
  logic [IDX_W-1:0]                   sel_q;
  logic [NUM_REGIONS-1:0][DATA_W-1:0] base_q;
  logic [NUM_REGIONS-1:0][DATA_W-1:0] attr_q;
  logic                               wr;

  assign wr = cfg_req_i && cfg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      base_q <= '0;
      attr_q <= '0;
    end else if (wr) begin
      case (cfg_addr_i)
        REG_CTRL: en_q          <= cfg_wdata_i[0];
        REG_SEL:  sel_q         <= cfg_wdata_i[IDX_W-1:0];
        REG_BASE: base_q[sel_q] <= cfg_wdata_i;
        default:  attr_q[sel_q] <= cfg_wdata_i;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr_i)
      REG_CTRL: cfg_rdata_o = DATA_W'(en_q);
      REG_SEL:  cfg_rdata_o = DATA_W'(sel_q);
      REG_BASE: cfg_rdata_o = base_q[sel_q];
      default:  cfg_rdata_o = attr_q[sel_q];
    endcase
  end

  assign glob_en_o = en_q;
  assign base_o    = base_q;
  assign attr_o    = attr_q;

  // R8
  base_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && cfg_addr_i == REG_BASE) |=> (base_q[$past(sel_q)] == $past(cfg_wdata_i)));
endmodule

// File: rtl/rg_region_match.sv
`timescale 1ns/1ps
module rg_region_match
  import rg_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] attr_i,
  output logic              match_o,
  output perm_t             perm_o
);
  localparam int unsigned SHW = $clog2(ADDR_W) + 1;

  logic [4:0]        size_n;
  logic [SHW-1:0]    shamt;
  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] keep_mask;

  assign size_n = attr_i[A_SIZE_HI:A_SIZE_LO];

  always_comb begin
    if (size_n < 5'(MIN_SIZE_LOG)) shamt = SHW'(MIN_SIZE_LOG + 1);
    else                           shamt = SHW'(size_n) + SHW'(1);
  end

  // span = region bytes; bit ADDR_W set only for the full-space size
  assign span      = (ADDR_W+1)'(1) << shamt;
  assign keep_mask = ~(span[ADDR_W-1:0] - ADDR_W'(1));
  assign match_o   = attr_i[A_EN] && ((addr_i & keep_mask) == (base_i & keep_mask));

  assign perm_o.p_rd = attr_i[A_PRD];
  assign perm_o.p_wr = attr_i[A_PWR];
  assign perm_o.p_xn = attr_i[A_PXN];
  assign perm_o.u_rd = attr_i[A_URD];
  assign perm_o.u_wr = attr_i[A_UWR];
  assign perm_o.u_xn = attr_i[A_UXN];

  logic unused_attr;
  assign unused_attr = ^{attr_i[ADDR_W-1:A_UXN+1], attr_i[A_PRD-1:A_SIZE_HI+1]};
endmodule

// File: rtl/rg_decide.sv
`timescale 1ns/1ps
module rg_decide
  import rg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           glob_en_i,
  input  logic [NUM_REGIONS-1:0]         match_i,
  input  perm_t [NUM_REGIONS-1:0]        perm_i,
  input  logic [1:0]                     acc_type_i,
  input  logic                           acc_priv_i,
  output logic                           allow_o,
  output logic                           hit_o,
  output logic [$clog2(NUM_REGIONS)-1:0] region_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS);

  perm_t sel_perm;
  logic  can_rd, can_wr, no_exec, perm_ok;

  // ascending scan: the last match, i.e. the highest index, wins
  always_comb begin
    hit_o    = 1'b0;
    region_o = '0;
    for (int i = 0; i < int'(NUM_REGIONS); i++) begin
      if (match_i[i]) begin
        hit_o    = 1'b1;
        region_o = IDX_W'(i);
      end
    end
  end

  assign sel_perm = perm_i[region_o];
  assign can_rd   = acc_priv_i ? sel_perm.p_rd : sel_perm.u_rd;
  assign can_wr   = acc_priv_i ? sel_perm.p_wr : sel_perm.u_wr;
  assign no_exec  = acc_priv_i ? sel_perm.p_xn : sel_perm.u_xn;

  always_comb begin
    case (acc_type_i)
      ACC_FETCH: perm_ok = can_rd && !no_exec;
      ACC_WRITE: perm_ok = can_wr;
      default:   perm_ok = can_rd;
    endcase
  end

  always_comb begin
    if (!glob_en_i)  allow_o = 1'b1;
    else if (!hit_o) allow_o = acc_priv_i;
    else             allow_o = perm_ok;
  end

  // R4
  top_match_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_i >> region_o) == NUM_REGIONS'(1)));

  // R4
  miss_index_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i == '0) |-> (!hit_o && region_o == '0));
endmodule

// File: rtl/region_guard.sv
`timescale 1ns/1ps
module region_guard
  import rg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_req_i,
  input  logic                           cfg_we_i,
  input  logic [1:0]                     cfg_addr_i,
  input  logic [ADDR_W-1:0]              cfg_wdata_i,
  output logic [ADDR_W-1:0]              cfg_rdata_o,
  input  logic [ADDR_W-1:0]              acc_addr_i,
  input  logic [1:0]                     acc_type_i,
  input  logic                           acc_priv_i,
  output logic [ADDR_W-1:0]              acc_addr_o,
  output logic                           acc_allow_o,
  output logic                           acc_fault_o,
  output logic                           acc_hit_o,
  output logic [$clog2(NUM_REGIONS)-1:0] acc_region_o
);
  logic                               glob_en;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] attr;
  logic [NUM_REGIONS-1:0]             match;
  perm_t [NUM_REGIONS-1:0]            perm;

  rg_cfg_regs #(
    .NUM_REGIONS(NUM_REGIONS),
    .DATA_W     (ADDR_W)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_req_i  (cfg_req_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .glob_en_o  (glob_en),
    .base_o     (base),
    .attr_o     (attr)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    rg_region_match #(.ADDR_W(ADDR_W)) i_match (
      .addr_i (acc_addr_i),
      .base_i (base[g]),
      .attr_i (attr[g]),
      .match_o(match[g]),
      .perm_o (perm[g])
    );
  end

  rg_decide #(.NUM_REGIONS(NUM_REGIONS)) i_decide (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .glob_en_i (glob_en),
    .match_i   (match),
    .perm_i    (perm),
    .acc_type_i(acc_type_i),
    .acc_priv_i(acc_priv_i),
    .allow_o   (acc_allow_o),
    .hit_o     (acc_hit_o),
    .region_o  (acc_region_o)
  );

  assign acc_fault_o = ~acc_allow_o;
  assign acc_addr_o  = acc_addr_i;

  // R7
  priv_miss_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fault_o |-> (acc_hit_o || !acc_priv_i));

  // R2
  off_never_faults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == REG_CTRL && cfg_rdata_o[0] == 1'b0) |-> !acc_fault_o);
endmodule

// File: tb/test_region_guard.sv
`timescale 1ns/1ps
module test_region_guard;
  localparam int NR = 8;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_req, cfg_we;
  logic [1:0]    cfg_addr;
  logic [AW-1:0] cfg_wdata, cfg_rdata;
  logic [AW-1:0] acc_addr, acc_addr_out;
  logic [1:0]    acc_type;
  logic          acc_priv, acc_allow, acc_fault, acc_hit;
  logic [2:0]    acc_region;

  always #4 clk = ~clk;

  region_guard #(.NUM_REGIONS(NR), .ADDR_W(AW)) i_region_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_req_i(cfg_req), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .acc_addr_i(acc_addr), .acc_type_i(acc_type), .acc_priv_i(acc_priv),
    .acc_addr_o(acc_addr_out), .acc_allow_o(acc_allow), .acc_fault_o(acc_fault),
    .acc_hit_o(acc_hit), .acc_region_o(acc_region)
  );

  typedef struct {
    logic        allow;
    logic        hit;
    logic [2:0]  rgn;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  event        drv_ev;
  int          n_vec = 0;
  int          n_bad = 0;
  logic [31:0] sh_base[NR];
  logic [31:0] sh_attr[NR];
  logic        sh_gen;
  logic [2:0]  sh_sel;

  function automatic logic [31:0] mk_attr(input logic en, input int n,
      input logic prd, input logic pwr, input logic urd, input logic uwr,
      input logic pxn, input logic uxn);
    return {18'd0, uxn, pxn, uwr, urd, pwr, prd, 2'b00, 5'(n), en};
  endfunction

  // independent model: range test on byte spans
  function automatic exp_t model(input logic [31:0] a, input logic [1:0] t,
                                 input logic p, input string tag);
    exp_t e;
    logic [63:0] sz, lo;
    logic [31:0] at;
    logic rd, wr, xn;
    int n;
    e.hit = 1'b0; e.rgn = 3'd0; e.addr = a; e.tag = tag;
    for (int r = 0; r < NR; r++) begin
      if (sh_attr[r][0]) begin
        n  = int'(sh_attr[r][5:1]);
        if (n < 4) n = 4;
        sz = 64'd1 << (n + 1);
        lo = {32'd0, sh_base[r]} & ~(sz - 64'd1);
        if ({32'd0, a} >= lo && {32'd0, a} < lo + sz) begin
          e.hit = 1'b1; e.rgn = 3'(r);
        end
      end
    end
    if (!sh_gen) e.allow = 1'b1;
    else if (!e.hit) e.allow = p;
    else begin
      at = sh_attr[e.rgn];
      rd = p ? at[8]  : at[10];
      wr = p ? at[9]  : at[11];
      xn = p ? at[12] : at[13];
      if (t == 2'd0)      e.allow = rd && !xn;
      else if (t == 2'd2) e.allow = wr;
      else                e.allow = rd;
    end
    return e;
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0;
    case (a)
      2'd0: sh_gen = d[0];
      2'd1: sh_sel = d[2:0];
      2'd2: sh_base[sh_sel] = d;
      default: sh_attr[sh_sel] = d;
    endcase
  endtask

  task automatic cfg_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    n_vec++;
    if (cfg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata=%h expected %h", tag, cfg_rdata, exp);
    end
  endtask

  task automatic set_region(input int r, input logic [31:0] b, input logic [31:0] at);
    cfg_write(2'd1, 32'(r));
    cfg_write(2'd2, b);
    cfg_write(2'd3, at);
  endtask

  task automatic drive(input logic [31:0] a, input logic [1:0] t, input logic p,
                       input string tag);
    @(negedge clk);
    acc_addr = a; acc_type = t; acc_priv = p;
    sb_q.push_back(model(a, t, p, tag));
    -> drv_ev;
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(drv_ev);
      #1;
      e = sb_q.pop_front();
      n_vec++;
      if (acc_allow !== e.allow || acc_hit !== e.hit || acc_region !== e.rgn) begin
        n_bad++;
        $display("FAIL %s: allow/hit/region=%b/%b/%0d expected %b/%b/%0d",
                 e.tag, acc_allow, acc_hit, acc_region, e.allow, e.hit, e.rgn);
      end
      n_vec++;
      if (acc_fault !== ~e.allow || acc_addr_out !== e.addr) begin
        n_bad++;
        $display("FAIL R9 %s: fault=%b addr=%h expected %b %h",
                 e.tag, acc_fault, acc_addr_out, ~e.allow, e.addr);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) begin sh_base[r] = '0; sh_attr[r] = '0; end
    sh_gen = 1'b0; sh_sel = 3'd0;
    rst_n = 1'b0; cfg_req = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = '0;
    acc_addr = '0; acc_type = 2'd0; acc_priv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cfg_check(2'd0, 32'd0, "R1 ctrl");
    cfg_check(2'd2, 32'd0, "R1 base0");
    cfg_check(2'd3, 32'd0, "R1 attr0");
    drive(32'h0000_1234, 2'd2, 1'b0, "R1 write after reset");

    set_region(0, 32'h0000_0000, mk_attr(1, 31, 1, 1, 1, 0, 0, 0));
    set_region(3, 32'h2000_0000, mk_attr(1, 15, 1, 1, 1, 1, 0, 0));
    set_region(5, 32'h2000_1008, mk_attr(1, 4,  1, 0, 0, 0, 1, 0));
    set_region(6, 32'h3000_0000, mk_attr(1, 2,  1, 0, 1, 0, 1, 0));
    set_region(7, 32'h2000_0000, mk_attr(0, 20, 0, 0, 0, 0, 0, 0));

    // R2 global off
    drive(32'h2000_1010, 2'd2, 1'b0, "R2 off user write");
    drive(32'h3000_0000, 2'd0, 1'b1, "R2 off priv fetch");
    cfg_write(2'd0, 32'd1);

    // R8 readback
    cfg_write(2'd1, 32'd5);
    cfg_check(2'd2, 32'h2000_1008, "R8 base5");
    cfg_check(2'd3, mk_attr(1, 4, 1, 0, 0, 0, 1, 0), "R8 attr5");
    cfg_check(2'd1, 32'd5, "R8 sel");
    cfg_write(2'd1, 32'hFFFF_FFFA);
    cfg_check(2'd1, 32'd2, "R8 sel masked");
    cfg_write(2'd3, 32'hA5A5_0000);
    cfg_check(2'd3, 32'hA5A5_0000, "R8 attr2 full word");
    cfg_check(2'd0, 32'd1, "R8 ctrl");

    // R5 permissions
    drive(32'h1000_0000, 2'd2, 1'b0, "R5 user write ro");
    drive(32'h1000_0000, 2'd1, 1'b0, "R5 user read");
    drive(32'h1000_0000, 2'd2, 1'b1, "R5 priv write");
    drive(32'h1000_0000, 2'd3, 1'b0, "R5 code3 as read");
    drive(32'h2000_1010, 2'd2, 1'b1, "R5 priv write ro region");
    drive(32'h2000_101F, 2'd1, 1'b0, "R5 user no read");
    // R4 overlap priority
    drive(32'h2000_0100, 2'd2, 1'b0, "R4 region3 over region0");
    // R3 windows
    drive(32'h2000_1000, 2'd1, 1'b1, "R3 misaligned base low edge");
    drive(32'h2000_1020, 2'd1, 1'b1, "R3 past 32B window");
    drive(32'h2000_FFFF, 2'd1, 1'b0, "R3 region3 top byte");
    drive(32'h2001_0000, 2'd2, 1'b0, "R3 past region3");
    drive(32'h3000_001F, 2'd1, 1'b0, "R3 clamped size inside");
    drive(32'h3000_0020, 2'd2, 1'b0, "R3 clamped size outside");
    drive(32'hFFFF_FFFC, 2'd1, 1'b1, "R3 full space top");
    // R6 fetch
    drive(32'h2000_101C, 2'd0, 1'b1, "R6 priv xn fetch");
    drive(32'h2000_FFF0, 2'd0, 1'b0, "R6 user fetch ok");
    drive(32'h3000_0004, 2'd0, 1'b0, "R6 user fetch region6");
    drive(32'h3000_0004, 2'd0, 1'b1, "R6 priv xn region6");
    drive(32'h2000_1004, 2'd0, 1'b0, "R6 user fetch no read");

    // R10 region enable
    drive(32'h2000_0100, 2'd1, 1'b0, "R10 region7 off");
    set_region(7, 32'h2000_0000, mk_attr(1, 20, 0, 0, 0, 0, 0, 0));
    drive(32'h2000_0100, 2'd1, 1'b0, "R10 region7 on");
    drive(32'h201F_FFFF, 2'd1, 1'b1, "R10 region7 top");
    set_region(7, 32'h2000_0000, mk_attr(0, 20, 0, 0, 0, 0, 0, 0));
    drive(32'h2000_0100, 2'd1, 1'b1, "R10 region7 off again");

    // R7 background
    set_region(0, 32'h0000_0000, mk_attr(0, 31, 1, 1, 1, 0, 0, 0));
    drive(32'h8000_0000, 2'd2, 1'b1, "R7 priv miss");
    drive(32'h8000_0000, 2'd1, 1'b0, "R7 user miss");
    drive(32'h8000_0000, 2'd0, 1'b0, "R7 user fetch miss");

    // R2 off again with table live
    cfg_write(2'd0, 32'hFFFF_FFFE);
    cfg_check(2'd0, 32'd0, "R2 ctrl bit0 only");
    drive(32'h8000_0000, 2'd1, 1'b0, "R2 off user miss");
    drive(32'h2000_1010, 2'd2, 1'b1, "R2 off priv write ro");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule